// File: doc/BRIEF.md
# Banked Operand Register File with Positional Reuse Cache

This block gathers the source operands of one instruction at a time. The operands come from a register file that is split into four banks. Each bank can do one read per cycle. An instruction names up to four source registers, one per operand position, and gives an enable bit for each. Operands whose registers sit in different banks are read in the same cycle. Operands that share a bank are read over several cycles. When all operands are present, a one-cycle done strobe presents them together with the number of bank-read cycles that were needed.

A small reuse cache sits in front of the banks and is managed by the compiler. Each operand position has its own two entries. The instruction carries a 4-bit hint mask, and a set bit asks that the operand at that position be kept for later instructions. A later read at the same position that names a cached register takes its value from the cache and does not use a bank.

Two events empty the cache, fully or in part:
- A thread switch clears every entry.
- A register write clears every entry that holds the written register.

A new instruction may be presented in any cycle where `ready` is high.

Top module: `opnd_collector`

## Requirements
- R1: Register r lives in bank r mod 4 (the two low index bits). If every enabled operand that misses the cache falls in a different bank, all operands are read in one cycle and `read_cycles` reports 1.
- R2: Operands that miss the cache and share a bank are read one per bank per cycle, in ascending position order. `read_cycles` equals the largest number of missing operands in any one bank.
- R3: An enabled operand whose register is held in a valid cache entry of its own position is returned from the cache and takes no bank read. An instruction served entirely from the cache reports `read_cycles` = 0.
- R4: A cache entry serves only its own operand position. A register cached at position p does not hit when it is named at another position.
- R5: After an instruction completes, every enabled position that missed and has its mask bit set is written into that position's cache. Positions with a clear mask bit leave the cache unchanged.
- R6: Each position holds two entries. A fill takes a free entry if there is one; otherwise it replaces the entry filled less recently.
- R7: A high `thread_sw` invalidates every cache entry at the next edge. A lookup in that same cycle sees no hits.
- R8: A write to register r invalidates every cache entry holding r. A later read of r returns the written value.
- R9: A position whose enable bit is clear is not read. It returns 0 and leaves its cache entries untouched, whatever its mask bit.
- R10: A request accepted while `ready` is high raises `done` for exactly one cycle. That cycle comes N+1 cycles after the acceptance cycle, where N = max(`read_cycles`, 1). `ready` is low for the N cycles in between.
- R11: A write in the same cycle as an accepted request is visible to that request. It is never served a stale cached copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Instruction present; accepted when `ready` is high |
| req_en | input | 4 | Per-position operand enable |
| req_idx | input | 4*IW | Register index per position, position p at bits [p*IW +: IW] |
| reuse_mask | input | 4 | Per-position cache fill hint |
| thread_sw | input | 1 | Active thread changes; clears the cache |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | IW | Register write index |
| wr_data | input | DW | Register write data |
| ready | output | 1 | Block idle, new request may be accepted |
| done | output | 1 | One-cycle strobe, operands valid |
| opnd_data | output | 4*DW | Operand values, position p at bits [p*DW +: DW] |
| read_cycles | output | 3 | Bank-read cycles used by the completed instruction |

## Verification
The bench targets bank conflicts at every multiplicity, from four distinct banks up to four operands in one bank. A wrong arbiter would either report too few read cycles or return the wrong register at a position. It also checks positional lookup and least-recently-filled eviction. A cache keyed only by register, or one that evicts a fixed entry, would show a hit where a miss is due, and the cycle count would give that away. Writes and thread switches, including a write in the acceptance cycle, are mixed with cached reads. A design that forgot an invalidation would return a stale value or finish early. Disabled positions carry set hints, so a design that filled them anyway would show false hits later.

// File: rtl/opnd_collector.sv
module opnd_collector #(
  parameter int NREG = 64,
  parameter int DW   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_vld,
  input  logic [3:0]            req_en,
  input  logic [4*$clog2(NREG)-1:0] req_idx,
  input  logic [3:0]            reuse_mask,
  input  logic                  thread_sw,
  input  logic                  wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]         wr_data,
  output logic                  ready,
  output logic                  done,
  output logic [4*DW-1:0]       opnd_data,
  output logic [2:0]            read_cycles
);
  localparam int NPOS = 4;
  localparam int IW   = $clog2(NREG);

  logic [DW-1:0] rf [NREG];
  logic busy, done_q;
  logic [NPOS-1:0] pend, fillq, killq, grant, hit, fill_ok, tgt;
  logic [IW-1:0] idx_q [NPOS];
  logic [IW-1:0] idx_in [NPOS];
  logic [DW-1:0] opq [NPOS];
  logic [DW-1:0] rd [NPOS];
  logic [DW-1:0] hdat [NPOS];
  logic [2:0] cnt;
  logic [1:0] cv [NPOS];
  logic [IW-1:0] ctag [NPOS][2];
  logic [DW-1:0] cdat [NPOS][2];
  logic [NPOS-1:0] vic;
  logic [2*NPOS-1:0] cv_flat;

  wire accept = req_vld && !busy;
  wire last   = busy && ((pend & ~grant) == '0);

  assign ready       = !busy;
  assign done        = done_q;
  assign read_cycles = cnt;

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    logic h0, h1, wr_hit_in;
    assign idx_in[p]  = req_idx[p*IW +: IW];
    assign wr_hit_in  = wr_en && (wr_idx == idx_in[p]);
    assign h0 = cv[p][0] && (ctag[p][0] == idx_in[p]);
    assign h1 = cv[p][1] && (ctag[p][1] == idx_in[p]);
    assign hit[p]  = req_en[p] && (h0 || h1) && !thread_sw && !wr_hit_in;
    assign hdat[p] = h0 ? cdat[p][0] : cdat[p][1];
    assign rd[p]   = rf[idx_q[p]];
    assign tgt[p]  = !cv[p][0] ? 1'b0 : (!cv[p][1] ? 1'b1 : vic[p]);
    assign fill_ok[p] = last && fillq[p] && !killq[p] && !thread_sw &&
                        !(wr_en && wr_idx == idx_q[p]);
    assign opnd_data[p*DW +: DW] = opq[p];
    assign cv_flat[2*p +: 2] = cv[p];
  end

  always_comb begin
    for (int p = 0; p < NPOS; p++) begin
      grant[p] = pend[p];
      for (int q = 0; q < p; q++)
        if (pend[q] && idx_q[q][1:0] == idx_q[p][1:0]) grant[p] = 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) rf[wr_idx] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      pend   <= '0;
      fillq  <= '0;
      killq  <= '0;
      cnt    <= '0;
      for (int p = 0; p < NPOS; p++) begin
        idx_q[p] <= '0;
        opq[p]   <= '0;
      end
    end else begin
      done_q <= last;
      if (accept) begin
        busy  <= 1'b1;
        pend  <= req_en & ~hit;
        fillq <= req_en & reuse_mask & ~hit;
        killq <= '0;
        cnt   <= '0;
        for (int p = 0; p < NPOS; p++) begin
          idx_q[p] <= idx_in[p];
          opq[p]   <= hit[p] ? hdat[p] : (req_en[p] ? opq[p] : '0);
        end
      end else if (busy) begin
        pend <= pend & ~grant;
        if (grant != '0) cnt <= cnt + 3'd1;
        if (last) busy <= 1'b0;
        for (int p = 0; p < NPOS; p++) begin
          if (grant[p]) opq[p] <= rd[p];
          if (thread_sw || (wr_en && wr_idx == idx_q[p])) killq[p] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vic <= '0;
      for (int p = 0; p < NPOS; p++) cv[p] <= '0;
    end else begin
      for (int p = 0; p < NPOS; p++) begin
        if (fill_ok[p]) begin
          cv[p][tgt[p]] <= 1'b1;
          vic[p] <= ~tgt[p];
        end
        if (thread_sw) begin
          cv[p]  <= '0;
          vic[p] <= 1'b0;
        end else if (wr_en) begin
          for (int e = 0; e < 2; e++)
            if (cv[p][e] && ctag[p][e] == wr_idx) cv[p][e] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk)
    for (int p = 0; p < NPOS; p++)
      if (fill_ok[p]) begin
        ctag[p][tgt[p]] <= idx_q[p];
        cdat[p][tgt[p]] <= grant[p] ? rd[p] : opq[p];
      end

  for (genvar b = 0; b < 4; b++) begin : g_bank_chk
    logic [NPOS-1:0] gb;
    for (genvar p = 0; p < NPOS; p++) begin : g_gb
      assign gb[p] = grant[p] && (idx_q[p][1:0] == b);
    end
    // R2
    bank_port_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gb));
  end

  for (genvar p = 0; p < NPOS; p++) begin : g_inv_chk
    for (genvar e = 0; e < 2; e++) begin : g_e
      // R8
      wr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !(cv[p][e] && ctag[p][e] == $past(wr_idx)));
    end
  end

  // R7
  switch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thread_sw |=> (cv_flat == '0));

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && ready));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (read_cycles <= 3'(NPOS)));
endmodule

// File: tb/tb_opnd_collector.sv
module tb_opnd_collector;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 64;
  localparam int DW = 32;
  localparam int IW = $clog2(NREG);

  logic clk = 0, rst_n = 0;
  logic req_vld = 0, thread_sw = 0, wr_en = 0;
  logic [3:0] req_en = 0, reuse_mask = 0;
  logic [4*IW-1:0] req_idx = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [DW-1:0] wr_data = 0;
  logic ready, done;
  logic [4*DW-1:0] opnd_data;
  logic [2:0] read_cycles;

  opnd_collector #(.NREG(NREG), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_en(req_en), .req_idx(req_idx),
    .reuse_mask(reuse_mask), .thread_sw(thread_sw), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ready(ready), .done(done), .opnd_data(opnd_data),
    .read_cycles(read_cycles));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_on = 0;
  string cur_tag = "R10";
  logic [DW-1:0] regs [NREG];
  int cq [4][$];
  int exp_done = -1, bstart = 1, bend = 0, exp_cnt = 0;
  logic [DW-1:0] exp_dat [4];
  int seed = 32'h1234_5677;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", cur_tag, what, act, expv, cyc);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk(done === (cyc == exp_done), "done", done, cyc == exp_done);
    chk(ready === !(cyc >= bstart && cyc <= bend), "ready", ready, !(cyc >= bstart && cyc <= bend));
    if (cyc == exp_done) begin
      chk(read_cycles === 3'(exp_cnt), "read_cycles", read_cycles, exp_cnt);
      for (int p = 0; p < 4; p++)
        chk(opnd_data[p*DW +: DW] === exp_dat[p], "operand", opnd_data[p*DW +: DW], exp_dat[p]);
    end
  end

  function automatic void mdl_write(input int a, input logic [DW-1:0] d);
    regs[a] = d;
    for (int p = 0; p < 4; p++)
      for (int i = cq[p].size() - 1; i >= 0; i--)
        if (cq[p][i] == a) cq[p].delete(i);
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_idx = IW'(a); wr_data = d;
    mdl_write(a, d);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic sw_pulse();
    @(negedge clk); #1;
    thread_sw = 1;
    for (int p = 0; p < 4; p++) cq[p].delete();
    @(negedge clk); #1;
    thread_sw = 0;
  endtask

  task automatic issue(input int i0, i1, i2, i3, input logic [3:0] en, mask,
                       input bit sw, wen, input int wa, input logic [DW-1:0] wd);
    int idx [4];
    int bc [4];
    bit h [4];
    int k;
    idx[0] = i0; idx[1] = i1; idx[2] = i2; idx[3] = i3;
    @(negedge clk); #1;
    if (sw) for (int p = 0; p < 4; p++) cq[p].delete();
    if (wen) mdl_write(wa, wd);
    for (int b = 0; b < 4; b++) bc[b] = 0;
    k = 0;
    for (int p = 0; p < 4; p++) begin
      h[p] = 0;
      if (en[p]) foreach (cq[p][i]) if (cq[p][i] == idx[p]) h[p] = 1;
      if (en[p] && !h[p]) bc[idx[p] % 4]++;
      exp_dat[p] = en[p] ? regs[idx[p]] : '0;
    end
    for (int b = 0; b < 4; b++) if (bc[b] > k) k = bc[b];
    exp_cnt = k;
    bstart = cyc + 1;
    bend = cyc + ((k > 1) ? k : 1);
    exp_done = bend + 1;
    for (int p = 0; p < 4; p++)
      if (en[p] && mask[p] && !h[p]) begin
        cq[p].push_back(idx[p]);
        if (cq[p].size() > 2) void'(cq[p].pop_front());
      end
    req_vld = 1; req_en = en; reuse_mask = mask;
    req_idx = {IW'(i3), IW'(i2), IW'(i1), IW'(i0)};
    thread_sw = sw; wr_en = wen; wr_idx = IW'(wa); wr_data = wd;
    @(negedge clk); #1;
    req_vld = 0; thread_sw = 0; wr_en = 0;
    while (cyc < exp_done) @(negedge clk);
  endtask

  task automatic rq(input int i0, i1, i2, i3, input logic [3:0] en, mask);
    issue(i0, i1, i2, i3, en, mask, 0, 0, 0, '0);
  endtask

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed & 32'h7fff_ffff;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    cur_tag = "R10";
    errors++;
    $display("FAIL R10 watchdog expired: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R10";
    chk(ready === 1'b1, "reset ready", ready, 1);
    chk(done === 1'b0, "reset done", done, 0);
    chk(read_cycles === 3'd0, "reset read_cycles", read_cycles, 0);
    chk(opnd_data === '0, "reset operands", opnd_data, 0);
    for (int i = 0; i < NREG; i++) wr(i, DW'(i) * 32'h9E37_79B1 + 32'h0101);
    mon_on = 1;

    cur_tag = "R1";  rq(0, 1, 2, 3, 4'hF, 4'h0);     // one read cycle
    cur_tag = "R2";  rq(0, 4, 8, 12, 4'hF, 4'h0);    // four in bank 0
    cur_tag = "R2";  rq(1, 5, 2, 6, 4'hF, 4'h0);     // two conflicts
    cur_tag = "R2";  rq(7, 11, 3, 9, 4'hF, 4'h0);    // three in bank 3
    cur_tag = "R5";  rq(16, 17, 18, 19, 4'hF, 4'hF);
    cur_tag = "R3";  rq(16, 17, 18, 19, 4'hF, 4'h0); // all hits, zero cycles
    cur_tag = "R4";  rq(17, 16, 19, 18, 4'hF, 4'h0); // swapped positions miss
    cur_tag = "R5";  rq(40, 44, 48, 52, 4'hF, 4'h0); // no mask: no fill
    cur_tag = "R5";  rq(40, 44, 48, 52, 4'hF, 4'h0);
    cur_tag = "R6";  rq(20, 0, 0, 0, 4'h1, 4'h1);
    cur_tag = "R6";  rq(24, 0, 0, 0, 4'h1, 4'h1);    // evicts 16
    cur_tag = "R6";  rq(16, 0, 0, 0, 4'h1, 4'h0);    // miss
    cur_tag = "R6";  rq(20, 0, 0, 0, 4'h1, 4'h0);    // hit
    cur_tag = "R8";  wr(20, 32'hDEAD_BEEF);
    cur_tag = "R8";  rq(20, 0, 0, 0, 4'h1, 4'h0);    // miss, new value
    cur_tag = "R6";  rq(28, 0, 0, 0, 4'h1, 4'h1);    // takes the freed entry
    cur_tag = "R6";  rq(24, 0, 0, 0, 4'h1, 4'h0);    // still cached
    cur_tag = "R7";  sw_pulse();
    cur_tag = "R7";  rq(24, 0, 0, 0, 4'h1, 4'h0);    // miss after switch
    cur_tag = "R9";  rq(32, 30, 33, 31, 4'h5, 4'hF);
    cur_tag = "R9";  rq(0, 30, 0, 31, 4'hA, 4'h0);   // disabled slots were not cached
    cur_tag = "R11"; rq(36, 0, 0, 0, 4'h1, 4'h1);
    cur_tag = "R11"; issue(36, 0, 0, 0, 4'h1, 4'h0, 0, 1, 36, 32'h0BAD_F00D);
    cur_tag = "R7";  rq(37, 0, 0, 0, 4'h1, 4'h1);
    cur_tag = "R7";  issue(37, 0, 0, 0, 4'h1, 4'h0, 1, 0, 0, '0);

    cur_tag = "R8";
    for (int n = 0; n < 120; n++) begin
      int r, s;
      r = rnd();
      s = rnd();
      issue(r & 15, (r >> 4) & 15, (r >> 8) & 15, (r >> 12) & 15,
            4'(s), 4'(s >> 4), (s % 13) == 0, (s % 5) == 0,
            (s >> 8) & 15, DW'(rnd()));
    end

    repeat (3) @(negedge clk);
    mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule